// File: doc/BRIEF.md
# Block-Protocol Configuration Register Slave

This block sits on a two-wire serial bus as a slave. It holds a small bank of configuration bytes that steer a clock generator. Typical contents are a spread-modulation enable in byte 0 and per-output enable masks in the bytes above it. The bank is presented in parallel on `cfg_o`, so the clock logic can use it without any further decoding. The bus lines arrive on open-drain style pins. SCL is input only, because the slave never stretches the clock. SDA has a separate input, an output value that is fixed at 0, and an output enable. Both lines are synchronized into the system clock domain and glitch filtered before any decision is made.

A write transfer starts with the device address for writing. Two bytes follow: a command code and a byte count. The slave acknowledges both and discards them. Data bytes come next and fill byte 0, then byte 1, and so on upward. The host may stop after any whole byte. A read transfer starts with the device address for reading. The slave answers with a byte count and then streams the bank from byte 0 up, continuing until the host declines a byte.

The bus has no valid/ready stream of its own. Pacing comes entirely from the host's SCL, and the slave never applies back-pressure. An unwanted byte is refused with a NACK. The configuration bus is a plain level output.

Top module: `blkcfg_i2c_slave`

## Requirements
- R1: After reset, `cfg_o` equals 48'hFFFF_FFFF_FF00 (byte k on bits 8k+7..8k: byte 0 = 00h, bytes 1..5 = FFh) and `sda_oe_o` is 0.
- R2: The slave acknowledges only the address bytes D2h (write) and D3h (read). For any other address it leaves SDA released until the next START.
- R3: In a write, the two bytes after the address are acknowledged and change no register.
- R4: The following data bytes, sent MSB first, are acknowledged and stored to byte 0, 1, 2 ... in that order. Each is stored on the SCL falling edge that ends its eighth bit.
- R5: A STOP after any complete byte ends the write. Bytes already stored keep their new values, and bytes not reached keep their old values.
- R6: Data bytes beyond the sixth are not acknowledged and change no register.
- R7: In a read, the slave sends the count 06h and then bytes 0..5, each MSB first. Every byte after byte 5 reads as FFh.
- R8: A NACK from the host in a read ends the transfer. SDA stays released through any further SCL pulses until the next START.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks is ignored. A repeated START aborts the current transfer and begins a new address phase.
- R10: The slave asserts its SDA drive only while the filtered SCL is low. It releases SDA while SCL is high only on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_o | output | 1 | Value driven on SDA when enabled (always 0) |
| sda_oe_o | output | 1 | SDA output enable; 1 pulls the line low |
| cfg_o | output | 48 | Configuration bank, byte k on bits 8k+7..8k |

## Verification
The write path is exercised in four forms: a full six-byte block, a two-byte block cut short by a STOP, a seven-byte overrun, and a one-byte write that ends in a repeated START. Together these distinguish a slave that stores bytes per byte from one that stores only at STOP, and a slave that wraps its index from one that refuses the extra byte. Reads are done both to completion, past byte 5, and with an early host NACK followed by extra SCL pulses. These show that the count byte leads the data, that padding appears after byte 5, and that SDA is truly released. A foreign address and a short SCL glitch inside a data byte check that the address match and the line filter are enforced, rather than only being present on the clean path.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } xfer_st_e;

  localparam logic [7:0] PAD_BYTE = 8'hFF;

endpackage

// File: rtl/blkcfg_line_filter.sv
module blkcfg_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  // R9
  glitch_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q));

endmodule

// File: rtl/blkcfg_bus_events.sv
module blkcfg_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_q;
  assign scl_fall_o = ~scl_f_i & scl_q;
  assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;

endmodule

// File: rtl/blkcfg_regbank.sv
module blkcfg_regbank #(
  parameter int NBYTES = 6,
  parameter logic [8*NBYTES-1:0] CFG_RESET = {{(NBYTES-1){8'hFF}}, 8'h00},
  localparam int IDX_W = $clog2(NBYTES + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [7:0]         rd_data_o,
  output logic [8*NBYTES-1:0] cfg_o
);
  logic [7:0] byte_q [NBYTES];

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q[k] <= CFG_RESET[8*k +: 8];
      else if (wr_en_i && (wr_idx_i == IDX_W'(k)))
        byte_q[k] <= wr_data_i;
    end
    assign cfg_o[8*k +: 8] = byte_q[k];
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NBYTES; k++)
      if (rd_idx_i == IDX_W'(k)) rd_data_o = byte_q[k];
  end

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(cfg_o));

  // R6
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (wr_idx_i < IDX_W'(NBYTES)));

endmodule

// File: rtl/blkcfg_engine.sv
module blkcfg_engine
  import blkcfg_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int IDX_W = $clog2(NBYTES + 2),
  localparam int PTR_W = $clog2(NBYTES + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f_i,
  input  logic             sda_f_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [7:0]       rd_data_i
);
  localparam logic [PTR_W-1:0] W_LIMIT = PTR_W'(NBYTES + 2);
  localparam logic [PTR_W-1:0] R_LAST  = PTR_W'(NBYTES);
  localparam logic [PTR_W-1:0] DUMMIES = PTR_W'(2);

  xfer_st_e         st_q;
  logic [7:0]       shreg_q;
  logic [2:0]       bitcnt_q;
  logic             byte_done_q;
  logic             is_read_q;
  logic             host_ack_q;
  logic             oe_q;
  logic [PTR_W-1:0] w_ptr_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [PTR_W-1:0] tx_sel;
  logic [7:0]       tx_byte;

  // byte chosen for transmission: count, bank byte, or padding
  always_comb begin
    tx_sel   = (st_q == ST_ADDR_ACK) ? '0 : rd_ptr_q;
    rd_idx_o = IDX_W'(tx_sel - 1'b1);
    if (tx_sel == '0)          tx_byte = 8'(NBYTES);
    else if (tx_sel <= R_LAST) tx_byte = rd_data_i;
    else                       tx_byte = PAD_BYTE;
  end

  assign wr_en_o   = (st_q == ST_WBYTE) && scl_fall_i && byte_done_q &&
                     !start_i && !stop_i &&
                     (w_ptr_q >= DUMMIES) && (w_ptr_q < W_LIMIT);
  assign wr_idx_o  = IDX_W'(w_ptr_q - DUMMIES);
  assign wr_data_o = shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      shreg_q     <= '0;
      bitcnt_q    <= '0;
      byte_done_q <= 1'b0;
      is_read_q   <= 1'b0;
      host_ack_q  <= 1'b0;
      oe_q        <= 1'b0;
      w_ptr_q     <= '0;
      rd_ptr_q    <= '0;
    end else if (start_i) begin
      st_q        <= ST_ADDR;
      bitcnt_q    <= '0;
      byte_done_q <= 1'b0;
      oe_q        <= 1'b0;
    end else if (stop_i) begin
      st_q        <= ST_IDLE;
      byte_done_q <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise_i && !byte_done_q) begin
            shreg_q <= {shreg_q[6:0], sda_f_i};
            if (bitcnt_q == 3'd7) byte_done_q <= 1'b1;
            else                  bitcnt_q    <= bitcnt_q + 1'b1;
          end else if (scl_fall_i && byte_done_q) begin
            byte_done_q <= 1'b0;
            bitcnt_q    <= '0;
            if (st_q == ST_ADDR) begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                oe_q      <= 1'b1;
                is_read_q <= shreg_q[0];
                w_ptr_q   <= '0;
                st_q      <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (w_ptr_q < W_LIMIT) begin
              oe_q    <= 1'b1;
              w_ptr_q <= w_ptr_q + 1'b1;
              st_q    <= ST_WACK;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            if (is_read_q) begin
              shreg_q  <= tx_byte;
              oe_q     <= ~tx_byte[7];
              rd_ptr_q <= PTR_W'(1);
              bitcnt_q <= '0;
              st_q     <= ST_RBYTE;
            end else begin
              oe_q <= 1'b0;
              st_q <= ST_WBYTE;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall_i) begin
            oe_q <= 1'b0;
            st_q <= ST_WBYTE;
          end
        end
        ST_RBYTE: begin
          if (scl_fall_i) begin
            if (bitcnt_q == 3'd7) begin
              oe_q     <= 1'b0;
              bitcnt_q <= '0;
              st_q     <= ST_RACK;
            end else begin
              shreg_q  <= {shreg_q[6:0], 1'b0};
              oe_q     <= ~shreg_q[6];
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            host_ack_q <= ~sda_f_i;
          end else if (scl_fall_i) begin
            if (host_ack_q) begin
              shreg_q <= tx_byte;
              oe_q    <= ~tx_byte[7];
              if (rd_ptr_q <= R_LAST) rd_ptr_q <= rd_ptr_q + 1'b1;
              st_q    <= ST_RBYTE;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  // R10
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !$past(oe_q)) |-> !scl_f_i);

  // R10
  release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_q && $past(oe_q) && scl_f_i) |-> $past(start_i || stop_i));

endmodule

// File: rtl/blkcfg_i2c_slave.sv
module blkcfg_i2c_slave #(
  parameter int NBYTES = 6,
  parameter int FILT_LEN = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [8*NBYTES-1:0] CFG_RESET = {{(NBYTES-1){8'hFF}}, 8'h00}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_o,
  output logic                sda_oe_o,
  output logic [8*NBYTES-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NBYTES + 2);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_rise, scl_fall, start_w, stop_w;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    blkcfg_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .filt_o (filt_lines[g])
    );
  end

  blkcfg_bus_events u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f_i    (filt_lines[0]),
    .sda_f_i    (filt_lines[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  blkcfg_engine #(.NBYTES(NBYTES), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f_i    (filt_lines[0]),
    .sda_f_i    (filt_lines[1]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx),
    .rd_data_i  (rd_data)
  );

  blkcfg_regbank #(.NBYTES(NBYTES), .CFG_RESET(CFG_RESET)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .cfg_o     (cfg_o)
  );

  assign sda_o = 1'b0;

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !sda_oe_o);

endmodule

// File: tb/sim_blkcfg_i2c_slave.sv
module sim_blkcfg_i2c_slave;
  localparam int NB = 6;
  localparam int QT = 25;
  localparam logic [47:0] RST_VAL = 48'hFFFF_FFFF_FF00;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_low = 1'b0;
  logic sda_o, sda_oe_o;
  logic [47:0] cfg_o;
  logic sda_bus;

  int tests = 0;
  int fails = 0;
  int mism = 0;
  bit cmp_en = 1'b0;
  bit oe_seen = 1'b0;
  logic [47:0] model = RST_VAL;

  always #2.5 clk = ~clk;

  assign sda_bus = ~(sda_low | sda_oe_o);

  blkcfg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe_o(sda_oe_o), .cfg_o(cfg_o)
  );

  // per-clock comparison against the behavioural register model
  always @(negedge clk) begin
    if (rst_n && cmp_en && (cfg_o !== model)) begin
      if (mism == 0)
        $display("FAIL R4 per-clock cfg act=%h exp=%h", cfg_o, model);
      mism++;
    end
    if (sda_oe_o) oe_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QT) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 1'b0; qwait();
    scl = 1'b1; qwait();
    sda_low = 1'b1; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; qwait();
    scl = 1'b1; qwait();
    sda_low = 1'b0; qwait(); qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_low = ~b[i]; qwait();
      if (glitch && i == 4) begin
        scl = 1'b1; @(negedge clk); @(negedge clk);
        scl = 1'b0; qwait();
      end
      scl = 1'b1; qwait(); qwait();
      scl = 1'b0; qwait();
    end
    sda_low = 1'b0; qwait();
    scl = 1'b1; qwait();
    ack = ~sda_bus;
    qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] v);
    sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl = 1'b1; qwait();
      v[i] = sda_bus;
      qwait();
      scl = 1'b0; qwait();
    end
    sda_low = ~nack; qwait();
    scl = 1'b1; qwait(); qwait();
    scl = 1'b0; qwait();
    sda_low = 1'b0;
  endtask

  task automatic do_write(input bq_t d, input bit glitch, input bit end_stop);
    bit ack;
    bus_start();
    send_byte(8'hD2, 1'b0, ack);
    chk(ack, "R2 write address ack", 64'(ack), 64'd1);
    send_byte(8'h5A, 1'b0, ack);
    chk(ack, "R3 command byte ack", 64'(ack), 64'd1);
    send_byte(8'h3C, 1'b0, ack);
    chk(ack, "R3 count byte ack", 64'(ack), 64'd1);
    foreach (d[k]) begin
      cmp_en = 1'b0;
      send_byte(d[k], glitch && k == 0, ack);
      if (k < NB) chk(ack, "R4 data byte ack", 64'(ack), 64'd1);
      else        chk(!ack, "R6 excess byte nack", 64'(ack), 64'd0);
      if (ack && k < NB) model[8*k +: 8] = d[k];
      cmp_en = 1'b1;
    end
    if (end_stop) bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(cfg_o == RST_VAL, "R1 reset cfg", 64'(cfg_o), 64'(RST_VAL));
    chk(!sda_oe_o, "R1 reset sda released", 64'(sda_oe_o), 64'd0);
    cmp_en = 1'b1;

    // R2: foreign address
    oe_seen = 1'b0;
    bus_start();
    send_byte(8'hA0, 1'b0, ack);
    send_byte(8'hD2, 1'b0, ack);
    bus_stop();
    chk(!oe_seen, "R2 foreign address ignored", 64'(oe_seen), 64'd0);

    // R3 R4: full block write
    do_write('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, 1'b0, 1'b1);
    chk(cfg_o == 48'h6655_4433_2211, "R4 full write", 64'(cfg_o), 64'h6655_4433_2211);

    // R7: full read plus padding
    bus_start();
    send_byte(8'hD3, 1'b0, ack);
    chk(ack, "R2 read address ack", 64'(ack), 64'd1);
    recv_byte(1'b0, v);
    chk(v == 8'h06, "R7 count byte", 64'(v), 64'h06);
    for (int k = 0; k < NB; k++) begin
      recv_byte(1'b0, v);
      chk(v == model[8*k +: 8], "R7 data byte", 64'(v), 64'(model[8*k +: 8]));
    end
    recv_byte(1'b1, v);
    chk(v == 8'hFF, "R7 padding byte", 64'(v), 64'hFF);
    bus_stop();

    // R5: partial write
    do_write('{8'hA1, 8'hB2}, 1'b0, 1'b1);
    chk(cfg_o == 48'h6655_4433_B2A1, "R5 partial write", 64'(cfg_o), 64'h6655_4433_B2A1);

    // R6 R9: overrun with SCL glitch inside first data byte
    do_write('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07}, 1'b1, 1'b1);
    chk(cfg_o == 48'h0605_0403_0201, "R6 R9 overrun and glitch", 64'(cfg_o), 64'h0605_0403_0201);

    // R9: write ended by repeated START then read
    do_write('{8'hC3}, 1'b0, 1'b0);
    bus_start();
    send_byte(8'hD3, 1'b0, ack);
    chk(ack, "R9 repeated start address ack", 64'(ack), 64'd1);
    recv_byte(1'b0, v);
    chk(v == 8'h06, "R9 count after repeated start", 64'(v), 64'h06);
    recv_byte(1'b1, v);
    chk(v == 8'hC3, "R9 byte0 after repeated start", 64'(v), 64'hC3);

    // R8: host NACK then extra clocks
    oe_seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    end
    chk(!oe_seen, "R8 released after nack", 64'(oe_seen), 64'd0);
    bus_stop();

    chk(cfg_o == model, "R5 final cfg", 64'(cfg_o), 64'(model));
    chk(mism == 0, "R3 R4 per-clock compare", 64'(mism), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule